// File: doc/BRIEF.md
# Shared Interrupt Best-Candidate Selector

This block looks at every shared interrupt and, for each of a set of processing elements, chooses the interrupt that should be signalled there next. It takes the per-interrupt pending, enable, active and group state as inputs, together with the global group enables. Each interrupt has an 8-bit priority and a 64-bit routing word, and the block keeps both itself. Software reaches them through a simple register access port. When security is enabled, non-secure priority accesses see a shifted view of the stored value.

A single comparator walks the interrupts one per clock. It finds the target of the current interrupt, either by matching the routing word against each element's affinity or, in any-target mode, by taking the first element that accepts such interrupts for the interrupt's group. It then keeps the best candidate for each element. When a pass finishes, the per-element winners are copied to the outputs. Any change on an input, and any register write, restarts the pass. A published result therefore always comes from one consistent state of the inputs.

Top module: `irqsel_hppi`

## Requirements
- R1: An interrupt is considered only if all four of these hold: it is pending, it is enabled, it is not active, and the enable bit for its group is set. Group codes are 0 = group 0 (enable bit 0), 1 = secure group 1 (enable bit 1) and 2 = non-secure group 1 (enable bit 2). Code 3 never qualifies.
- R2: For each element, the candidate with the numerically lowest priority wins. On equal priority, the lower interrupt ID wins.
- R3: An element with no candidate shows valid 0, priority 0xFF, ID 0 and group 0. An interrupt whose stored priority is 0xFF is never selected.
- R4: When routing bit 31 is clear, the target is the lowest-index element whose 32-bit affinity equals {route[39:32], route[23:0]}.
- R5: When routing bit 31 is set, the target is the lowest-index element whose any-target accept bit for the interrupt's group is set. These bits are laid out as pe_any_ok_i[3*pe + group].
- R6: An interrupt that matches no element is not signalled on any element.
- R7: With security enabled, a non-secure priority write to a non-secure group 1 interrupt stores 0x80 | (value >> 1), and a non-secure read returns (stored << 1) & 0xFF. Secure accesses, and any access with security disabled, see the raw byte.
- R8: With security enabled, a non-secure priority read of an interrupt that is not non-secure group 1 returns 0, and a non-secure priority write to such an interrupt changes nothing.
- R9: After reset every priority reads 0xAA, every routing word reads 0, and all outputs show no candidate.
- R10: A routing access with acc_hi_i set reads or writes bits 63:32 of the word. With acc_hi_i clear it reads or writes bits 31:0. The other half is left unchanged.
- R11: The reported ID is BASE_ID + interrupt index. Within 2*NUM_IRQ+3 cycles of the last input change or write, the outputs equal the selection for the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pend_i | input | NUM_IRQ | Pending flag per interrupt |
| irq_en_i | input | NUM_IRQ | Enable flag per interrupt |
| irq_act_i | input | NUM_IRQ | Active flag per interrupt |
| irq_grp_i | input | 2*NUM_IRQ | Group code per interrupt |
| grp_en_i | input | 3 | Enable per group code |
| sec_en_i | input | 1 | Security enabled |
| pe_aff_i | input | 32*NUM_PE | Affinity of each element |
| pe_any_ok_i | input | 3*NUM_PE | Any-target acceptance per element and group |
| acc_wr_i | input | 1 | Register write strobe |
| acc_sel_route_i | input | 1 | 1 selects the routing word, 0 selects the priority byte |
| acc_ns_i | input | 1 | Access is non-secure |
| acc_idx_i | input | IDX_W | Interrupt index accessed |
| acc_hi_i | input | 1 | Selects the upper half of the routing word |
| acc_wdata_i | input | 32 | Write data |
| acc_rdata_o | output | 32 | Read data for the current access fields |
| hp_valid_o | output | NUM_PE | A candidate exists for the element |
| hp_id_o | output | ID_W*NUM_PE | Winning interrupt ID |
| hp_prio_o | output | 8*NUM_PE | Winning priority |
| hp_grp_o | output | 2*NUM_PE | Winning group code |

## Verification
The translation and write-ignore properties assume that the group code of the accessed interrupt stays the same in the cycle of the write. They also assume that only one write happens per clock. The bench meets both by changing group inputs only between accesses and by holding each write strobe for exactly one cycle. The output properties assume nothing about the inputs. The bench compares the outputs against its own model only after holding all inputs still for longer than two full passes.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;
  localparam logic [7:0] PRIO_NONE  = 8'hFF;
  localparam logic [7:0] PRIO_RESET = 8'hAA;
  localparam logic [1:0] GRP_G0     = 2'd0;
  localparam logic [1:0] GRP_G1S    = 2'd1;
  localparam logic [1:0] GRP_G1NS   = 2'd2;
  localparam int         ROUTE_ANY_BIT = 31;
  localparam int         AFF_W      = 32;
  localparam int         ROUTE_W    = 64;
endpackage

// File: rtl/irqsel_prio_bank.sv
module irqsel_prio_bank
  import irqsel_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  localparam int IDX_W = $clog2(NUM_IRQ)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 ns_view,
  input  logic [IDX_W-1:0]     idx,
  input  logic [7:0]           wdata,
  input  logic [2*NUM_IRQ-1:0] grp_flat,
  output logic [8*NUM_IRQ-1:0] prio_flat,
  output logic [7:0]           rdata
);
  logic [1:0] sel_grp;
  logic [7:0] sel_prio;
  logic [7:0] store_val;

  assign sel_grp   = grp_flat[idx*2 +: 2];
  assign sel_prio  = prio_flat[idx*8 +: 8];
  assign store_val = ns_view ? (8'h80 | (wdata >> 1)) : wdata;

  always_comb begin
    if (!ns_view)                 rdata = sel_prio;
    else if (sel_grp != GRP_G1NS) rdata = 8'h00;
    else                          rdata = {sel_prio[6:0], 1'b0};
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_prio
    logic       hit;
    logic [7:0] val_d;
    logic [7:0] val_q;
    assign hit = wr_en && (idx == IDX_W'(i)) &&
                 !(ns_view && (grp_flat[i*2 +: 2] != GRP_G1NS));
    always_comb val_d = hit ? store_val : val_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= PRIO_RESET;
      else        val_q <= val_d;
    end
    assign prio_flat[i*8 +: 8] = val_q;
  end
endmodule

// File: rtl/irqsel_route_bank.sv
module irqsel_route_bank
  import irqsel_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  localparam int IDX_W = $clog2(NUM_IRQ)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           idx,
  input  logic                       hi,
  input  logic [31:0]                wdata,
  output logic [ROUTE_W*NUM_IRQ-1:0] route_flat,
  output logic [31:0]                rdata
);
  logic [ROUTE_W-1:0] sel_route;
  assign sel_route = route_flat[idx*ROUTE_W +: ROUTE_W];
  assign rdata     = hi ? sel_route[63:32] : sel_route[31:0];

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_route
    logic               hit;
    logic [ROUTE_W-1:0] val_d;
    logic [ROUTE_W-1:0] val_q;
    assign hit = wr_en && (idx == IDX_W'(i));
    always_comb begin
      val_d = val_q;
      if (hit) begin
        if (hi) val_d[63:32] = wdata;
        else    val_d[31:0]  = wdata;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= '0;
      else        val_q <= val_d;
    end
    assign route_flat[i*ROUTE_W +: ROUTE_W] = val_q;
  end
endmodule

// File: rtl/irqsel_target_pick.sv
module irqsel_target_pick
  import irqsel_pkg::*;
#(
  parameter int NUM_PE = 4
) (
  input  logic [ROUTE_W-1:0]      route,
  input  logic [1:0]              grp,
  input  logic [AFF_W*NUM_PE-1:0] pe_aff,
  input  logic [3*NUM_PE-1:0]     pe_any_ok,
  output logic                    found,
  output logic [NUM_PE-1:0]       tgt_oh
);
  logic [AFF_W-1:0]  key;
  logic [NUM_PE-1:0] elig;

  assign key = {route[39:32], route[23:0]};

  for (genvar t = 0; t < NUM_PE; t++) begin : g_elig
    assign elig[t] = route[ROUTE_ANY_BIT] ?
                     ((grp != 2'd3) && pe_any_ok[t*3 + int'(grp)]) :
                     (pe_aff[t*AFF_W +: AFF_W] == key);
  end

  always_comb begin
    found  = 1'b0;
    tgt_oh = '0;
    for (int t = 0; t < NUM_PE; t++) begin
      if (!found && elig[t]) begin
        tgt_oh[t] = 1'b1;
        found     = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irqsel_hppi.sv
module irqsel_hppi
  import irqsel_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int NUM_PE  = 4,
  parameter int BASE_ID = 32,
  parameter int ID_W    = 10,
  localparam int IDX_W  = $clog2(NUM_IRQ)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_IRQ-1:0]      irq_pend_i,
  input  logic [NUM_IRQ-1:0]      irq_en_i,
  input  logic [NUM_IRQ-1:0]      irq_act_i,
  input  logic [2*NUM_IRQ-1:0]    irq_grp_i,
  input  logic [2:0]              grp_en_i,
  input  logic                    sec_en_i,
  input  logic [32*NUM_PE-1:0]    pe_aff_i,
  input  logic [3*NUM_PE-1:0]     pe_any_ok_i,
  input  logic                    acc_wr_i,
  input  logic                    acc_sel_route_i,
  input  logic                    acc_ns_i,
  input  logic [IDX_W-1:0]        acc_idx_i,
  input  logic                    acc_hi_i,
  input  logic [31:0]             acc_wdata_i,
  output logic [31:0]             acc_rdata_o,
  output logic [NUM_PE-1:0]       hp_valid_o,
  output logic [ID_W*NUM_PE-1:0]  hp_id_o,
  output logic [8*NUM_PE-1:0]     hp_prio_o,
  output logic [2*NUM_PE-1:0]     hp_grp_o
);
  localparam int SNAP_W = 5*NUM_IRQ + 4 + 35*NUM_PE;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_IRQ - 1);

  logic [8*NUM_IRQ-1:0]       prio_flat;
  logic [ROUTE_W*NUM_IRQ-1:0] route_flat;
  logic [7:0]                 prio_rd;
  logic [31:0]                route_rd;

  irqsel_prio_bank #(.NUM_IRQ(NUM_IRQ)) u_prio (
    .clk(clk), .rst_n(rst_n),
    .wr_en(acc_wr_i && !acc_sel_route_i),
    .ns_view(acc_ns_i && sec_en_i),
    .idx(acc_idx_i), .wdata(acc_wdata_i[7:0]),
    .grp_flat(irq_grp_i), .prio_flat(prio_flat), .rdata(prio_rd)
  );

  irqsel_route_bank #(.NUM_IRQ(NUM_IRQ)) u_route (
    .clk(clk), .rst_n(rst_n),
    .wr_en(acc_wr_i && acc_sel_route_i),
    .idx(acc_idx_i), .hi(acc_hi_i), .wdata(acc_wdata_i),
    .route_flat(route_flat), .rdata(route_rd)
  );

  assign acc_rdata_o = acc_sel_route_i ? route_rd : {24'h0, prio_rd};

  // change detection: any input edit or write restarts the pass
  logic [SNAP_W-1:0] snap, snap_q;
  logic              chg;
  assign snap = {irq_pend_i, irq_en_i, irq_act_i, irq_grp_i, grp_en_i,
                 sec_en_i, pe_aff_i, pe_any_ok_i};
  assign chg  = (snap != snap_q) || acc_wr_i;

  // candidate under the scan pointer
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [1:0]         cand_grp;
  logic [7:0]         cand_prio;
  logic [ID_W-1:0]    cand_id;
  logic               grp_ok, cand_ok, tgt_found;
  logic [NUM_PE-1:0]  tgt_oh;

  assign cand_grp  = irq_grp_i[idx_q*2 +: 2];
  assign cand_prio = prio_flat[idx_q*8 +: 8];
  assign cand_id   = ID_W'(BASE_ID) + ID_W'(idx_q);

  always_comb begin
    case (cand_grp)
      GRP_G0:   grp_ok = grp_en_i[0];
      GRP_G1S:  grp_ok = grp_en_i[1];
      GRP_G1NS: grp_ok = grp_en_i[2];
      default:  grp_ok = 1'b0;
    endcase
  end

  assign cand_ok = irq_pend_i[idx_q] && irq_en_i[idx_q] &&
                   !irq_act_i[idx_q] && grp_ok;

  irqsel_target_pick #(.NUM_PE(NUM_PE)) u_pick (
    .route(route_flat[idx_q*ROUTE_W +: ROUTE_W]), .grp(cand_grp),
    .pe_aff(pe_aff_i), .pe_any_ok(pe_any_ok_i),
    .found(tgt_found), .tgt_oh(tgt_oh)
  );

  // per-element running best
  logic [NUM_PE-1:0]           wk_val_q, wk_val_d;
  logic [NUM_PE-1:0][7:0]      wk_prio_q, wk_prio_d;
  logic [NUM_PE-1:0][ID_W-1:0] wk_id_q, wk_id_d;
  logic [NUM_PE-1:0][1:0]      wk_grp_q, wk_grp_d;
  logic                        publish;

  always_comb begin
    for (int t = 0; t < NUM_PE; t++) begin
      if (idx_q == '0) begin
        wk_val_d[t]  = 1'b0;
        wk_prio_d[t] = PRIO_NONE;
        wk_id_d[t]   = '0;
        wk_grp_d[t]  = '0;
      end else begin
        wk_val_d[t]  = wk_val_q[t];
        wk_prio_d[t] = wk_prio_q[t];
        wk_id_d[t]   = wk_id_q[t];
        wk_grp_d[t]  = wk_grp_q[t];
      end
      if (cand_ok && tgt_found && tgt_oh[t] && (cand_prio < wk_prio_d[t])) begin
        wk_val_d[t]  = 1'b1;
        wk_prio_d[t] = cand_prio;
        wk_id_d[t]   = cand_id;
        wk_grp_d[t]  = cand_grp;
      end
    end
    idx_d   = (chg || idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
    publish = !chg && (idx_q == LAST_IDX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q    <= '0;
      idx_q     <= '0;
      wk_val_q  <= '0;
      wk_prio_q <= {NUM_PE{PRIO_NONE}};
      wk_id_q   <= '0;
      wk_grp_q  <= '0;
    end else begin
      snap_q    <= snap;
      idx_q     <= idx_d;
      wk_val_q  <= wk_val_d;
      wk_prio_q <= wk_prio_d;
      wk_id_q   <= wk_id_d;
      wk_grp_q  <= wk_grp_d;
    end
  end

  // published results, loaded only at the end of a clean pass
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hp_valid_o <= '0;
      hp_id_o    <= '0;
      hp_prio_o  <= {NUM_PE{PRIO_NONE}};
      hp_grp_o   <= '0;
    end else if (publish) begin
      hp_valid_o <= wk_val_d;
      hp_id_o    <= wk_id_d;
      hp_prio_o  <= wk_prio_d;
      hp_grp_o   <= wk_grp_d;
    end
  end
endmodule

// File: rtl/irqsel_hppi_chk.sv
module irqsel_hppi_chk
  import irqsel_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int NUM_PE  = 4,
  parameter int BASE_ID = 32,
  parameter int ID_W    = 10,
  localparam int IDX_W  = $clog2(NUM_IRQ)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       acc_wr_i,
  input logic                       acc_sel_route_i,
  input logic                       acc_ns_i,
  input logic [IDX_W-1:0]           acc_idx_i,
  input logic                       acc_hi_i,
  input logic [31:0]                acc_wdata_i,
  input logic                       sec_en_i,
  input logic [2*NUM_IRQ-1:0]       irq_grp_i,
  input logic [8*NUM_IRQ-1:0]       prio_flat,
  input logic [ROUTE_W*NUM_IRQ-1:0] route_flat,
  input logic [NUM_PE-1:0]          hp_valid_o,
  input logic [ID_W*NUM_PE-1:0]     hp_id_o,
  input logic [8*NUM_PE-1:0]        hp_prio_o
);
  logic ns_prio_wr;
  assign ns_prio_wr = acc_wr_i && !acc_sel_route_i && acc_ns_i && sec_en_i;

  AST_NS_PRIO_XLATE: assert property (@(posedge clk) disable iff (!rst_n)
    ns_prio_wr && (irq_grp_i[acc_idx_i*2 +: 2] == GRP_G1NS) |=>
    prio_flat[$past(acc_idx_i)*8 +: 8] == (8'h80 | ($past(acc_wdata_i[7:0]) >> 1))); // R7

  AST_NS_PRIO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    ns_prio_wr && (irq_grp_i[acc_idx_i*2 +: 2] != GRP_G1NS) |=>
    $stable(prio_flat)); // R8

  AST_ROUTE_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr_i && acc_sel_route_i && !acc_hi_i |=>
    route_flat[$past(acc_idx_i)*ROUTE_W + 32 +: 32] ==
    $past(route_flat[acc_idx_i*ROUTE_W + 32 +: 32])); // R10

  for (genvar t = 0; t < NUM_PE; t++) begin : g_out
    AST_IDLE_PRIO_NONE: assert property (@(posedge clk) disable iff (!rst_n)
      !hp_valid_o[t] |-> hp_prio_o[t*8 +: 8] == PRIO_NONE); // R3
    AST_VALID_PRIO_REAL: assert property (@(posedge clk) disable iff (!rst_n)
      hp_valid_o[t] |-> hp_prio_o[t*8 +: 8] != PRIO_NONE); // R3
    AST_ID_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      hp_valid_o[t] |-> (hp_id_o[t*ID_W +: ID_W] >= ID_W'(BASE_ID)) &&
                        (hp_id_o[t*ID_W +: ID_W] < ID_W'(BASE_ID + NUM_IRQ))); // R11
  end
endmodule

bind irqsel_hppi irqsel_hppi_chk #(
  .NUM_IRQ(NUM_IRQ), .NUM_PE(NUM_PE), .BASE_ID(BASE_ID), .ID_W(ID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_wr_i(acc_wr_i),
  .acc_sel_route_i(acc_sel_route_i), .acc_ns_i(acc_ns_i),
  .acc_idx_i(acc_idx_i), .acc_hi_i(acc_hi_i), .acc_wdata_i(acc_wdata_i),
  .sec_en_i(sec_en_i), .irq_grp_i(irq_grp_i), .prio_flat(prio_flat),
  .route_flat(route_flat), .hp_valid_o(hp_valid_o), .hp_id_o(hp_id_o),
  .hp_prio_o(hp_prio_o)
);

// File: tb/irqsel_hppi_tb.sv
module irqsel_hppi_tb;
  localparam int N    = 16;
  localparam int P    = 4;
  localparam int BASE = 32;
  localparam int IDW  = 10;
  localparam int IW   = $clog2(N);

  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  logic [N-1:0]    pend, en, act;
  logic [2*N-1:0]  grp;
  logic [2:0]      grp_en;
  logic            sec_en;
  logic [32*P-1:0] pe_aff;
  logic [3*P-1:0]  any_ok;
  logic            acc_wr, acc_route, acc_ns, acc_hi;
  logic [IW-1:0]   acc_idx;
  logic [31:0]     acc_wdata, acc_rdata;
  logic [P-1:0]    hp_valid;
  logic [IDW*P-1:0] hp_id;
  logic [8*P-1:0]  hp_prio;
  logic [2*P-1:0]  hp_grp;

  irqsel_hppi #(.NUM_IRQ(N), .NUM_PE(P), .BASE_ID(BASE), .ID_W(IDW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .irq_pend_i(pend), .irq_en_i(en), .irq_act_i(act), .irq_grp_i(grp),
    .grp_en_i(grp_en), .sec_en_i(sec_en), .pe_aff_i(pe_aff),
    .pe_any_ok_i(any_ok), .acc_wr_i(acc_wr), .acc_sel_route_i(acc_route),
    .acc_ns_i(acc_ns), .acc_idx_i(acc_idx), .acc_hi_i(acc_hi),
    .acc_wdata_i(acc_wdata), .acc_rdata_o(acc_rdata),
    .hp_valid_o(hp_valid), .hp_id_o(hp_id), .hp_prio_o(hp_prio), .hp_grp_o(hp_grp)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0]  m_prio [N];
  logic [63:0] m_route [N];

  task automatic check(string req, string what, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic settle();
    repeat (2*N + 6) @(negedge clk);
  endtask

  task automatic wr_prio(int i, logic [7:0] v, bit ns);
    @(negedge clk);
    acc_wr = 1'b1; acc_route = 1'b0; acc_ns = ns; acc_idx = IW'(i);
    acc_hi = 1'b0; acc_wdata = {24'h0, v};
    @(negedge clk);
    acc_wr = 1'b0; acc_ns = 1'b0;
    if (ns && sec_en) begin
      if (grp[i*2 +: 2] == 2'd2) m_prio[i] = 8'h80 | (v >> 1);
    end else m_prio[i] = v;
  endtask

  task automatic wr_route(int i, bit hi, logic [31:0] v);
    @(negedge clk);
    acc_wr = 1'b1; acc_route = 1'b1; acc_ns = 1'b0; acc_idx = IW'(i);
    acc_hi = hi; acc_wdata = v;
    @(negedge clk);
    acc_wr = 1'b0;
    if (hi) m_route[i][63:32] = v; else m_route[i][31:0] = v;
  endtask

  task automatic rd(bit route, bit ns, bit hi, int i, output logic [31:0] v);
    @(negedge clk);
    acc_route = route; acc_ns = ns; acc_hi = hi; acc_idx = IW'(i);
    #1 v = acc_rdata;
    acc_ns = 1'b0;
  endtask

  // reference: minimum over qualifying interrupts per element
  task automatic compare_all(string req);
    logic [P-1:0]   ev;
    logic [7:0]     ep [P];
    logic [IDW-1:0] ei [P];
    logic [1:0]     eg [P];
    settle();
    ev = '0;
    for (int t = 0; t < P; t++) begin ep[t] = 8'hFF; ei[t] = '0; eg[t] = '0; end
    for (int i = 0; i < N; i++) begin
      logic [1:0] g;
      bit q;
      int tgt;
      g = grp[i*2 +: 2];
      q = pend[i] && en[i] && !act[i] && (g != 2'd3) && grp_en[g];
      tgt = -1;
      for (int t = 0; t < P; t++) begin
        if (tgt < 0) begin
          if (m_route[i][31]) begin
            if (g != 2'd3 && any_ok[t*3 + int'(g)]) tgt = t;
          end else if (pe_aff[t*32 +: 32] == {m_route[i][39:32], m_route[i][23:0]}) tgt = t;
        end
      end
      if (q && tgt >= 0 && m_prio[i] < ep[tgt]) begin
        ev[tgt] = 1'b1; ep[tgt] = m_prio[i]; ei[tgt] = IDW'(BASE + i); eg[tgt] = g;
      end
    end
    for (int t = 0; t < P; t++)
      check(req, $sformatf("pe%0d {valid,id,prio,grp}", t),
            {44'h0, hp_valid[t], hp_id[t*IDW +: IDW], hp_prio[t*8 +: 8], hp_grp[t*2 +: 2]},
            {44'h0, ev[t], ei[t], ep[t], eg[t]});
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R9", "valid after reset", {60'h0, hp_valid}, 64'h0);
    check("R9", "prio after reset", {32'h0, hp_prio}, {32'h0, {P{8'hFF}}});
    rd(1'b0, 1'b0, 1'b0, 7, v);  check("R9", "prio reset", {32'h0, v}, 64'hAA);
    rd(1'b1, 1'b0, 1'b1, 3, v);  check("R9", "route reset hi", {32'h0, v}, 64'h0);
    compare_all("R3");
  endtask

  task automatic t_priority();
    pend = '1; en = '1; act = '0; grp = {N{2'd2}}; grp_en = 3'b111;
    compare_all("R11");
    check("R11", "lowest id wins on reset priorities", {54'h0, hp_id[IDW-1:0]}, 64'd32);
    wr_prio(5, 8'h10, 1'b0);
    compare_all("R2");
    check("R2", "lower priority value wins", {54'h0, hp_id[IDW-1:0]}, 64'd37);
    wr_prio(9, 8'h10, 1'b0);
    compare_all("R2");
    wr_prio(3, 8'h10, 1'b0);
    compare_all("R2");
    check("R2", "tie goes to lower id", {54'h0, hp_id[IDW-1:0]}, 64'd35);
  endtask

  task automatic t_qualify();
    act[3] = 1'b1;      compare_all("R1");
    en[5] = 1'b0;       compare_all("R1");
    check("R1", "disabled and active skipped", {54'h0, hp_id[IDW-1:0]}, 64'd41);
    grp[9*2 +: 2] = 2'd0; grp_en = 3'b110; compare_all("R1");
    grp[0*2 +: 2] = 2'd3; grp_en = 3'b111; compare_all("R1");
    pend = '0;          compare_all("R1");
    pend = '1; act = '0; en = '1; grp = {N{2'd2}};
  endtask

  task automatic t_route();
    logic [31:0] v;
    wr_route(2, 1'b0, 32'h0000_0001);
    wr_route(4, 1'b0, 32'h0001_0000);
    wr_route(6, 1'b0, 32'h0000_0002);
    wr_route(6, 1'b1, 32'h0000_0001);
    wr_route(7, 1'b0, 32'h0000_0005);
    compare_all("R4");
    check("R4", "pe3 affinity match", {54'h0, hp_id[3*IDW +: IDW]}, 64'd38);
    rd(1'b1, 1'b0, 1'b0, 6, v); check("R10", "route lo kept", {32'h0, v}, 64'h2);
    rd(1'b1, 1'b0, 1'b1, 6, v); check("R10", "route hi", {32'h0, v}, 64'h1);
    // irq 7 targets nobody: only it pending
    pend = 16'h0080; compare_all("R6");
    check("R6", "unrouted not signalled", {60'h0, hp_valid}, 64'h0);
    pend = '1;
    wr_prio(4, 8'hFF, 1'b0);
    compare_all("R3");
    check("R3", "0xFF priority never wins", {63'h0, hp_valid[2]}, 64'h0);
  endtask

  task automatic t_any();
    wr_route(8, 1'b0, 32'h8000_0000);
    wr_prio(8, 8'h01, 1'b0);
    any_ok = {3'b000, 3'b100, 3'b100, 3'b001};
    compare_all("R5");
    check("R5", "first accepting element", {54'h0, hp_id[1*IDW +: IDW]}, 64'd40);
    any_ok = '0; compare_all("R6");
  endtask

  task automatic t_ns();
    logic [31:0] v;
    sec_en = 1'b1;
    wr_prio(10, 8'h40, 1'b1);
    rd(1'b0, 1'b0, 1'b0, 10, v); check("R7", "ns write stored", {32'h0, v}, 64'hA0);
    rd(1'b0, 1'b1, 1'b0, 10, v); check("R7", "ns read view", {32'h0, v}, 64'h40);
    grp[11*2 +: 2] = 2'd0;
    wr_prio(11, 8'h00, 1'b1);
    rd(1'b0, 1'b0, 1'b0, 11, v); check("R8", "ns write ignored", {32'h0, v}, 64'hAA);
    rd(1'b0, 1'b1, 1'b0, 11, v); check("R8", "ns read zero", {32'h0, v}, 64'h0);
    compare_all("R8");
    sec_en = 1'b0;
    wr_prio(12, 8'h33, 1'b1);
    rd(1'b0, 1'b1, 1'b0, 12, v); check("R7", "security off raw", {32'h0, v}, 64'h33);
    compare_all("R7");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    pend = '0; en = '0; act = '0; grp = '0; grp_en = '0; sec_en = 1'b0;
    pe_aff = {32'h0100_0002, 32'h0001_0000, 32'h0000_0001, 32'h0000_0000};
    any_ok = '0;
    acc_wr = 1'b0; acc_route = 1'b0; acc_ns = 1'b0; acc_hi = 1'b0;
    acc_idx = '0; acc_wdata = '0;
    for (int i = 0; i < N; i++) begin m_prio[i] = 8'hAA; m_route[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_priority();
    t_qualify();
    t_route();
    t_any();
    t_ns();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule